// File: doc/BRIEF.md
# Bit-Scan and Zero-Count Unit

This execution unit answers four questions about a source operand of 16, 32 or 64 bits. It can find the position of the lowest set bit or of the highest set bit (the scan forms). It can also count the zero bits below the lowest set bit or above the highest set bit (the count forms). A count-select input picks the count forms over the scan forms, in the way a repeat-style prefix does on the scan opcodes. A direction input picks the low end or the high end of the operand.

The two families differ when the source is all zeros. A scan leaves the destination exactly as it was and raises ZF, so the caller supplies the old destination value. A count returns the operand width and raises CF. In that case ZF follows the count result, not the source. The unit merges the new value into the 64-bit destination according to the operand size. It registers the destination value and both flags with a one-cycle valid strobe.

Top module: `bit_scan_unit`

## Requirements
- R1: `valid_o` rises in the cycle after `valid_i` is sampled high. `result_o`, `zf_o` and `cf_o` update only on a sampled `valid_i` and otherwise hold their values.
- R2: While `rst_ni` is low, `valid_o`, `result_o`, `zf_o` and `cf_o` are all 0.
- R3: `size_i` encodes the operand width as 2'b00 = 16 bits, 2'b01 = 32 bits, and 2'b10 or 2'b11 = 64 bits. Source bits above the operand width are ignored.
- R4: Forward scan (`cnt_sel_i`=0, `rev_i`=0) on a nonzero operand returns the index of the lowest set bit, with ZF=0 and CF=0. CF is always 0 for both scan forms.
- R5: Reverse scan (`cnt_sel_i`=0, `rev_i`=1) on a nonzero operand returns the index of the highest set bit, with ZF=0.
- R6: A scan of a zero operand returns `dst_old_i` unchanged in all 64 bits, with ZF=1 and CF=0.
- R7: Trailing count (`cnt_sel_i`=1, `rev_i`=0) returns the same value as a forward scan for a nonzero operand. For a zero operand it returns the operand width (16, 32 or 64).
- R8: Leading count (`cnt_sel_i`=1, `rev_i`=1) returns width-1 minus the highest set index for a nonzero operand. For a zero operand it returns the operand width.
- R9: For the count forms, ZF=1 exactly when the count is 0, and CF=1 exactly when the operand is zero.
- R10: When the destination is written, a 16-bit operation keeps bits 63:16 of `dst_old_i`. A 32-bit operation zero-fills bits 63:32. A 64-bit operation writes all bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request |
| src_i | input | 64 | Source operand |
| dst_old_i | input | 64 | Current destination value |
| size_i | input | 2 | Operand size code |
| cnt_sel_i | input | 1 | 1 selects count forms, 0 selects scan forms |
| rev_i | input | 1 | 1 selects high end (reverse/leading), 0 low end |
| result_o | output | 64 | New destination value |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |
| valid_o | output | 1 | Result strobe |

## Verification
The bench builds the unit with its default 64-bit datapath, so all three operand sizes and the reserved size code can be exercised. At that width, the 16-bit merge that keeps upper destination bits and the 32-bit zero-fill can both be observed against a patterned old destination value. Sources that set bits only above the operand width show that those bits are ignored. Zero operands are run at every width to separate the scan behaviour, which keeps the old destination, from the count behaviour, which returns the width.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [1:0] {
    SZ_16  = 2'b00,
    SZ_32  = 2'b01,
    SZ_64  = 2'b10,
    SZ_64X = 2'b11
  } op_size_e;

  typedef struct packed {
    logic zf;
    logic cf;
  } flags_t;
endpackage

// File: rtl/bsu_operand.sv
module bsu_operand
  import bsu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0]  src_i,
  input  logic [1:0]       size_i,
  output logic [XLEN-1:0]  op_o,
  output logic [IDX_W-1:0] width_o
);
  localparam int HW = XLEN / 2;
  localparam int QW = XLEN / 4;

  op_size_e sz;
  assign sz = op_size_e'(size_i);

  always_comb begin
    unique case (sz)
      SZ_16: begin
        op_o    = {{(XLEN-QW){1'b0}}, src_i[QW-1:0]};
        width_o = IDX_W'(QW);
      end
      SZ_32: begin
        op_o    = {{(XLEN-HW){1'b0}}, src_i[HW-1:0]};
        width_o = IDX_W'(HW);
      end
      default: begin
        op_o    = src_i;
        width_o = IDX_W'(XLEN);
      end
    endcase
  end
endmodule

// File: rtl/bsu_find.sv
module bsu_find #(
  parameter int XLEN     = 64,
  parameter int IDX_W    = $clog2(XLEN) + 1,
  parameter bit FROM_TOP = 1'b0
) (
  input  logic [XLEN-1:0]  vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  assign any_o = |vec_i;

  generate
    if (FROM_TOP) begin : g_high
      // ascending walk, last hit is the highest set bit
      always_comb begin
        idx_o = '0;
        for (int i = 0; i < XLEN; i++)
          if (vec_i[i]) idx_o = IDX_W'(i);
      end
    end else begin : g_low
      // descending walk, last hit is the lowest set bit
      always_comb begin
        idx_o = '0;
        for (int i = XLEN - 1; i >= 0; i--)
          if (vec_i[i]) idx_o = IDX_W'(i);
      end
    end
  endgenerate
endmodule

// File: rtl/bsu_merge.sv
module bsu_merge
  import bsu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = $clog2(XLEN) + 1
) (
  input  logic             cnt_sel_i,
  input  logic             rev_i,
  input  logic [1:0]       size_i,
  input  logic [IDX_W-1:0] width_i,
  input  logic [IDX_W-1:0] lsb_i,
  input  logic [IDX_W-1:0] msb_i,
  input  logic             any_i,
  input  logic [XLEN-1:0]  dst_old_i,
  output logic [XLEN-1:0]  res_o,
  output flags_t           flags_o
);
  localparam int HW = XLEN / 2;
  localparam int QW = XLEN / 4;

  logic [IDX_W-1:0] cnt_val, scan_val, val;
  logic [XLEN-1:0]  ext;
  logic             keep;

  always_comb begin
    if (!any_i)     cnt_val = width_i;
    else if (rev_i) cnt_val = width_i - IDX_W'(1) - msb_i;
    else            cnt_val = lsb_i;
    scan_val = rev_i ? msb_i : lsb_i;
    val      = cnt_sel_i ? cnt_val : scan_val;
    keep     = !cnt_sel_i && !any_i;
    ext      = {{(XLEN-IDX_W){1'b0}}, val};
  end

  always_comb begin
    if (keep) res_o = dst_old_i;
    else begin
      unique case (op_size_e'(size_i))
        SZ_16:   res_o = {dst_old_i[XLEN-1:QW], ext[QW-1:0]};
        SZ_32:   res_o = {{(XLEN-HW){1'b0}}, ext[HW-1:0]};
        default: res_o = ext;
      endcase
    end
    flags_o.zf = cnt_sel_i ? (val == '0) : !any_i;
    flags_o.cf = cnt_sel_i && !any_i;
  end
endmodule

// File: rtl/bit_scan_unit.sv
module bit_scan_unit
  import bsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] dst_old_i,
  input  logic [1:0]      size_i,
  input  logic            cnt_sel_i,
  input  logic            rev_i,
  output logic [XLEN-1:0] result_o,
  output logic            zf_o,
  output logic            cf_o,
  output logic            valid_o
);
  localparam int IDX_W = $clog2(XLEN) + 1;

  logic [XLEN-1:0]  op;
  logic [IDX_W-1:0] width, lsb, msb;
  logic             any_lo, any_hi;
  logic [XLEN-1:0]  res_d;
  flags_t           flags_d;

  bsu_operand #(.XLEN(XLEN), .IDX_W(IDX_W)) u_operand (
    .src_i(src_i), .size_i(size_i), .op_o(op), .width_o(width)
  );

  bsu_find #(.XLEN(XLEN), .IDX_W(IDX_W), .FROM_TOP(1'b0)) u_find_lo (
    .vec_i(op), .idx_o(lsb), .any_o(any_lo)
  );

  bsu_find #(.XLEN(XLEN), .IDX_W(IDX_W), .FROM_TOP(1'b1)) u_find_hi (
    .vec_i(op), .idx_o(msb), .any_o(any_hi)
  );

  bsu_merge #(.XLEN(XLEN), .IDX_W(IDX_W)) u_merge (
    .cnt_sel_i(cnt_sel_i), .rev_i(rev_i), .size_i(size_i), .width_i(width),
    .lsb_i(lsb), .msb_i(msb), .any_i(any_lo | any_hi), .dst_old_i(dst_old_i),
    .res_o(res_d), .flags_o(flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      zf_o     <= 1'b0;
      cf_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        zf_o     <= flags_d.zf;
        cf_o     <= flags_d.cf;
      end
    end
  end
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [XLEN-1:0] src_i,
  input logic [XLEN-1:0] dst_old_i,
  input logic [1:0]      size_i,
  input logic            cnt_sel_i,
  input logic            rev_i,
  input logic [XLEN-1:0] result_o,
  input logic            zf_o,
  input logic            cf_o,
  input logic            valid_o
);
  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(zf_o) && $stable(cf_o)));

  p_scan_no_cf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cnt_sel_i) |=> !cf_o);

  p_scan_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cnt_sel_i && src_i == '0) |=> (result_o == $past(dst_old_i) && zf_o));

  p_cnt_zero64_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cnt_sel_i && size_i[1] && src_i == '0) |=> (result_o == XLEN'(XLEN) && cf_o));

  p_cnt_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cnt_sel_i) |=> ((zf_o == (result_o[XLEN/4-1:0] == '0)) && !(zf_o && cf_o)));

  p_zero_ext32_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'b01 && (cnt_sel_i || src_i[XLEN/2-1:0] != '0))
      |=> (result_o[XLEN-1:XLEN/2] == '0));
endmodule

bind bit_scan_unit bsu_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bit_scan_unit_tb.sv
module bit_scan_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] src_i = '0;
  logic [63:0] dst_old_i = '0;
  logic [1:0]  size_i = '0;
  logic        cnt_sel_i = 1'b0;
  logic        rev_i = 1'b0;
  logic [63:0] result_o;
  logic        zf_o, cf_o, valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [63:0] OLD = 64'hDEAD_BEEF_CAFE_F00D;

  always #10ns clk = ~clk;

  bit_scan_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .src_i(src_i),
    .dst_old_i(dst_old_i), .size_i(size_i), .cnt_sel_i(cnt_sel_i), .rev_i(rev_i),
    .result_o(result_o), .zf_o(zf_o), .cf_o(cf_o), .valid_o(valid_o)
  );

  task automatic check(string req, logic [63:0] act_r, logic [63:0] exp_r,
                       logic act_z, logic exp_z, logic act_c, logic exp_c);
    checks++;
    if (act_r !== exp_r || act_z !== exp_z || act_c !== exp_c) begin
      errors++;
      $display("FAIL %s: result=%h zf=%b cf=%b expected result=%h zf=%b cf=%b",
               req, act_r, act_z, act_c, exp_r, exp_z, exp_c);
    end
  endtask

  task automatic run_op(string req, logic [63:0] src, logic [1:0] sz, logic cnt,
                        logic rev, logic [63:0] exp_r, logic exp_z, logic exp_c);
    @(negedge clk);
    src_i = src; dst_old_i = OLD; size_i = sz; cnt_sel_i = cnt; rev_i = rev;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    checks++;
    if (valid_o !== 1'b1) begin
      errors++;
      $display("FAIL R1 (%s): valid_o=%b expected 1", req, valid_o);
    end
    check(req, result_o, exp_r, zf_o, exp_z, cf_o, exp_c);
  endtask

  task automatic t_reset;
    check("R2", result_o, 64'h0, zf_o, 1'b0, cf_o, 1'b0);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R2: valid_o=%b expected 0", valid_o);
    end
  endtask

  task automatic t_scan_fwd;
    run_op("R4", 64'h0000_0100_0000_0000, 2'b10, 1'b0, 1'b0, 64'd40, 1'b0, 1'b0);
    // R3 R10: upper bits ignored, 32-bit result zero-extended
    run_op("R3", 64'hFFFF_FFFF_0000_0008, 2'b01, 1'b0, 1'b0, 64'd3, 1'b0, 1'b0);
  endtask

  task automatic t_scan_rev;
    run_op("R5", 64'h8000_0000_0000_0001, 2'b10, 1'b0, 1'b1, 64'd63, 1'b0, 1'b0);
    run_op("R10", 64'hFFFF_FFFF_FFFF_0300, 2'b00, 1'b0, 1'b1,
           64'hDEAD_BEEF_CAFE_0009, 1'b0, 1'b0);
  endtask

  task automatic t_scan_zero;
    run_op("R6", 64'h0, 2'b10, 1'b0, 1'b0, OLD, 1'b1, 1'b0);
    run_op("R6", 64'hFFFF_FFFF_0000_0000, 2'b01, 1'b0, 1'b1, OLD, 1'b1, 1'b0);
    run_op("R6", 64'hFFFF_FFFF_FFFF_0000, 2'b00, 1'b0, 1'b0, OLD, 1'b1, 1'b0);
  endtask

  task automatic t_tz;
    run_op("R7", 64'h0000_0000_0000_0001, 2'b01, 1'b1, 1'b0, 64'd0, 1'b1, 1'b0);
    run_op("R7", 64'h0010_0000_0000_0000, 2'b10, 1'b1, 1'b0, 64'd52, 1'b0, 1'b0);
    run_op("R7", 64'hFFFF_FFFF_0000_0000, 2'b01, 1'b1, 1'b0, 64'd32, 1'b0, 1'b1);
    run_op("R9", 64'h0, 2'b00, 1'b1, 1'b0, 64'hDEAD_BEEF_CAFE_0010, 1'b0, 1'b1);
  endtask

  task automatic t_lz;
    run_op("R8", 64'h0000_0000_0000_0001, 2'b01, 1'b1, 1'b1, 64'd31, 1'b0, 1'b0);
    run_op("R8", 64'h0000_0001_0000_0000, 2'b10, 1'b1, 1'b1, 64'd31, 1'b0, 1'b0);
    run_op("R8", 64'h0, 2'b10, 1'b1, 1'b1, 64'd64, 1'b0, 1'b1);
    run_op("R9", 64'h0000_0000_0000_8000, 2'b00, 1'b1, 1'b1,
           64'hDEAD_BEEF_CAFE_0000, 1'b1, 1'b0);
    // R3: size code 2'b11 behaves as 64 bits
    run_op("R3", 64'h8000_0000_0000_0000, 2'b11, 1'b1, 1'b1, 64'd0, 1'b1, 1'b0);
  endtask

  task automatic t_hold;
    run_op("R1", 64'h0000_0000_0000_0040, 2'b10, 1'b0, 1'b0, 64'd6, 1'b0, 1'b0);
    @(negedge clk);
    src_i = 64'h0; cnt_sel_i = 1'b1; size_i = 2'b10; valid_i = 1'b0;
    @(negedge clk);
    check("R1", result_o, 64'd6, zf_o, 1'b0, cf_o, 1'b0);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid_o=%b expected 0", valid_o);
    end
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_scan_fwd();
    t_scan_rev();
    t_scan_zero();
    t_tz();
    t_lz();
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule